// File: doc/BRIEF.md
# Chained-Difference Function Table with Thermometer Selection

This block is a combinational, fully random-access function table. It does not hold one entry per input value. It keeps one full-width base entry for every block of 2Δ consecutive inputs, at the centre of that block. It also keeps Δ narrow tables of signed steps between neighbouring function values. The steps run outward from each centre. The lower half of a block steps backwards from the centre, and the upper half steps forwards. To rebuild f(α), the block adds to the base value a contiguous run of steps. That run ends next to the centre.

An address generator splits the n-bit input into three parts. The first is a direct address that reads the base table and the last step table, which is half depth. The second is an indirect address that reads the other step tables. The third is a Δ-bit thermometer select, formed by a shift and an XOR. The select masks the unused steps to zero. The summation makes every signed step unsigned by inverting its sign bit. It corrects for all of these inversions with a single constant, computed ahead of time and placed in the upper bits of the lowest operand. No sign extension is needed. The tabulated function is f(α) = ((α − 2^(n−1))² >> (n−3)) + 100. This function has both falling and rising stretches, so steps of both signs occur.

Top module: `dlut_top`

## Requirements
- R1: For every input α in 0 … 2^n−1, the output equals ((α − 2^(n−1))² >> (n−3)) + 100, with α treated as an unsigned integer and the arithmetic shift applied to a non-negative square.
- R2: Let low be the value of α[log2Δ−1:0] and let half be α[log2Δ]. Select bit i is 1 exactly when (half = 0 and i ≥ low) or (half = 1 and i < low).
- R3: When α[log2Δ:0] equals Δ (a block centre), the select is all zeros and the output is the stored centre value f(α).
- R4: When α[log2Δ:0] is zero (a block start), the select is all ones, so all Δ step tables contribute.
- R5: In the upper half of a block (α[log2Δ] = 1), select bit Δ−1 is 0, so the half-depth table is never used there.
- R6: In the lower half of a block (α[log2Δ] = 0), select bit Δ−1 is 1.
- R7: The extreme inputs 0 and 2^n−1 return f(0) and f(2^n−1). The first is the largest value of the function and the second ends a forward chain of Δ−1 steps.
- R8: The number of ones in the select equals |α − c|, where c is the centre of the block that contains α.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| alpha_i | input | N | Table input α |
| value_o | output | K | Reconstructed function value f(α) |
| sel_o | output | DELTA | Thermometer select applied to the step tables |

## Verification
The bench builds two instances. The first uses n = 8, k = 12, Δ = 4, d = 6. The second uses n = 7, k = 12, Δ = 8, d = 6. The Δ = 8 instance has a three-bit shift amount and chains of up to eight steps. Both instances are swept over every input, so every centre, block start and half-depth entry is covered, along with both signs of step. Randomly drawn inputs from a fixed seed then revisit the tables in a scattered order.

// File: rtl/dlut_pkg.sv
package dlut_pkg;

  // tabulated function: a parabola centred mid-range, lifted by 100
  function automatic int tab_fn(int x, int n);
    int c;
    c = x - (1 << (n - 1));
    return ((c * c) >>> (n - 3)) + 100;
  endfunction

  // lower half of a block: step from point k toward the centre
  function automatic int back_step(int grp, int k, int n, int dl);
    int b;
    b = grp * 2 * dl;
    return tab_fn(b + k, n) - tab_fn(b + k + 1, n);
  endfunction

  // upper half of a block: step away from the centre
  function automatic int fwd_step(int grp, int k, int n, int dl);
    int c;
    c = grp * 2 * dl + dl;
    return tab_fn(c + k + 1, n) - tab_fn(c + k, n);
  endfunction

  // constant that undoes all sign-bit inversions at once
  function automatic int sign_fold(int d, int dl);
    return -(dl * (1 << (d - 1)));
  endfunction

endpackage

// File: rtl/dlut_addr_gen.sv
module dlut_addr_gen #(
  parameter int N     = 8,
  parameter int DELTA = 4
) (
  input  logic [N-1:0]        alpha,
  output logic [N-2-$clog2(DELTA):0] direct_addr,
  output logic [N-1-$clog2(DELTA):0] indirect_addr,
  output logic [DELTA-1:0]    sel
);
  localparam int LG = $clog2(DELTA);

  assign direct_addr   = alpha[N-1:LG+1];
  assign indirect_addr = alpha[N-1:LG];
  assign sel = ({DELTA{1'b1}} << alpha[LG-1:0]) ^ {DELTA{alpha[LG]}};
endmodule

// File: rtl/dlut_base_table.sv
module dlut_base_table #(
  parameter int N     = 8,
  parameter int K     = 12,
  parameter int DELTA = 4
) (
  input  logic [N-2-$clog2(DELTA):0] direct_addr,
  output logic [K-1:0]        mval
);
  localparam int DW = N - 1 - $clog2(DELTA);

  always_comb begin
    int v;
    v = dlut_pkg::tab_fn(int'(direct_addr) * 2 * DELTA + DELTA, N);
    mval = v[K-1:0];
  end
endmodule

// File: rtl/dlut_diff_bank.sv
module dlut_diff_bank #(
  parameter int N     = 8,
  parameter int D     = 6,
  parameter int DELTA = 4
) (
  input  logic [N-2-$clog2(DELTA):0] direct_addr,
  input  logic [N-1-$clog2(DELTA):0] indirect_addr,
  input  logic [DELTA-1:0]           sel,
  output logic [DELTA-1:0][D-1:0]    dsel
);
  localparam int IW = N - $clog2(DELTA);

  logic [DELTA-1:0][D-1:0] dval;

  for (genvar k = 0; k < DELTA - 1; k++) begin : g_full
    always_comb begin
      int v;
      if (indirect_addr[0])
        v = dlut_pkg::fwd_step(int'(indirect_addr[IW-1:1]), k, N, DELTA);
      else
        v = dlut_pkg::back_step(int'(indirect_addr[IW-1:1]), k, N, DELTA);
      dval[k] = v[D-1:0];
    end
  end

  // half-depth table, shared address with the base table
  always_comb begin
    int v;
    v = dlut_pkg::back_step(int'(direct_addr), DELTA - 1, N, DELTA);
    dval[DELTA-1] = v[D-1:0];
  end

  for (genvar k = 0; k < DELTA; k++) begin : g_mask
    assign dsel[k] = dval[k] & {D{sel[k]}};
  end
endmodule

// File: rtl/dlut_signed_sum.sv
module dlut_signed_sum #(
  parameter int K     = 12,
  parameter int D     = 6,
  parameter int DELTA = 4
) (
  input  logic [K-1:0]             mval,
  input  logic [DELTA-1:0][D-1:0]  dsel,
  output logic [K-1:0]             sum
);
  localparam int          FOLD_I = dlut_pkg::sign_fold(D, DELTA);
  localparam logic [K-1:0] FOLD  = FOLD_I[K-1:0];

  logic [DELTA-1:0][D-1:0] uop;
  logic [K-1:0]            op0;

  for (genvar i = 0; i < DELTA; i++) begin : g_flip
    assign uop[i] = {~dsel[i][D-1], dsel[i][D-2:0]};
  end

  // low D bits of the fold constant are zero, so it concatenates
  assign op0 = {FOLD[K-1:D], uop[0]};

  always_comb begin
    logic [K-1:0] acc;
    acc = mval + op0;
    for (int i = 1; i < DELTA; i++)
      acc = acc + {{(K-D){1'b0}}, uop[i]};
    sum = acc;
  end
endmodule

// File: rtl/dlut_top.sv
module dlut_top #(
  parameter int N     = 8,
  parameter int K     = 12,
  parameter int D     = 6,
  parameter int DELTA = 4
) (
  input  logic [N-1:0]     alpha_i,
  output logic [K-1:0]     value_o,
  output logic [DELTA-1:0] sel_o
);
  localparam int LG = $clog2(DELTA);
  localparam int DW = N - 1 - LG;
  localparam int IW = N - LG;

  logic [DW-1:0]           direct_addr;
  logic [IW-1:0]           indirect_addr;
  logic [DELTA-1:0]        sel;
  logic [K-1:0]            mval;
  logic [DELTA-1:0][D-1:0] dsel;

  dlut_addr_gen #(.N(N), .DELTA(DELTA)) u_addr (
    .alpha(alpha_i), .direct_addr(direct_addr),
    .indirect_addr(indirect_addr), .sel(sel)
  );

  dlut_base_table #(.N(N), .K(K), .DELTA(DELTA)) u_base (
    .direct_addr(direct_addr), .mval(mval)
  );

  dlut_diff_bank #(.N(N), .D(D), .DELTA(DELTA)) u_bank (
    .direct_addr(direct_addr), .indirect_addr(indirect_addr),
    .sel(sel), .dsel(dsel)
  );

  dlut_signed_sum #(.K(K), .D(D), .DELTA(DELTA)) u_sum (
    .mval(mval), .dsel(dsel), .sum(value_o)
  );

  assign sel_o = sel;
endmodule

// File: rtl/dlut_chk.sv
module dlut_chk #(
  parameter int N     = 8,
  parameter int K     = 12,
  parameter int DELTA = 4
) (
  input logic [N-1:0]     a,
  input logic [K-1:0]     y,
  input logic [K-1:0]     mval,
  input logic [DELTA-1:0] sel
);
  localparam int LG = $clog2(DELTA);

  always_comb begin
    int f;
    int lo;
    f  = dlut_pkg::tab_fn(int'(a), N);
    lo = int'(a[LG-1:0]);
    // R1
    fn_match_chk: assert (int'(y) == f) else $error("value mismatch");
    // R3
    centre_chk: assert (!(a[LG] && lo == 0) || (sel == '0 && y == mval))
      else $error("centre point not pass-through");
    // R4
    start_chk: assert (!(!a[LG] && lo == 0) || &sel)
      else $error("block start select not full");
    // R5
    odd_top_chk: assert (!a[LG] || !sel[DELTA-1])
      else $error("half-depth table used in upper half");
    // R6
    even_top_chk: assert (a[LG] || sel[DELTA-1])
      else $error("half-depth table unused in lower half");
    // R8
    run_len_chk: assert ($countones(sel) == (a[LG] ? lo : DELTA - lo))
      else $error("select run length wrong");
  end
endmodule

bind dlut_top dlut_chk #(.N(N), .K(K), .DELTA(DELTA)) u_chk (
  .a(alpha_i), .y(value_o), .mval(mval), .sel(sel_o)
);

// File: tb/dlut_top_tb.sv
module dlut_top_tb;
  localparam int NA = 8, DA = 4;
  localparam int NB = 7, DB = 8;
  localparam int KW = 12, DW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [NA-1:0] alpha_a = '0;
  logic [NB-1:0] alpha_b = '0;
  logic [KW-1:0] val_a, val_b;
  logic [DA-1:0] sel_a;
  logic [DB-1:0] sel_b;

  int n_chk = 0;
  int n_bad = 0;

  dlut_top #(.N(NA), .K(KW), .D(DW), .DELTA(DA)) u_dut (
    .alpha_i(alpha_a), .value_o(val_a), .sel_o(sel_a)
  );
  dlut_top #(.N(NB), .K(KW), .D(DW), .DELTA(DB)) u_dut_w (
    .alpha_i(alpha_b), .value_o(val_b), .sel_o(sel_b)
  );

  function automatic int ref_f(int x, int n);
    int sq;
    sq = (x - (1 << (n - 1))) * (x - (1 << (n - 1)));
    return sq / (1 << (n - 3)) + 100;
  endfunction

  // select rebuilt from the distance rule, bit by bit
  function automatic int ref_sel(int x, int dl);
    int lo, half, r;
    lo = x % dl;
    half = (x / dl) % 2;
    r = 0;
    for (int i = 0; i < dl; i++)
      if ((half == 0 && i >= lo) || (half == 1 && i < lo)) r = r | (1 << i);
    return r;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic probe_a(int x, string tag);
    @(posedge clk); alpha_a = x[NA-1:0];
    @(negedge clk);
    check({tag, " R1 value"}, int'(val_a), ref_f(x, NA));
    check({tag, " R2 select"}, int'(sel_a), ref_sel(x, DA));
    if ((x % (2*DA)) == DA) begin
      check({tag, " R3 centre select"}, int'(sel_a), 0);
    end
    if ((x % (2*DA)) == 0) check({tag, " R4 start select"}, int'(sel_a), (1 << DA) - 1);
    if ((x / DA) % 2 == 1) check({tag, " R5 top bit"}, int'(sel_a[DA-1]), 0);
    else                   check({tag, " R6 top bit"}, int'(sel_a[DA-1]), 1);
  endtask

  task automatic probe_b(int x, string tag);
    int c;
    @(posedge clk); alpha_b = x[NB-1:0];
    @(negedge clk);
    c = (x / (2*DB)) * 2 * DB + DB;
    check({tag, " R1 value"}, int'(val_b), ref_f(x, NB));
    check({tag, " R2 select"}, int'(sel_b), ref_sel(x, DB));
    check({tag, " R8 run length"}, $countones(sel_b), (x > c) ? x - c : c - x);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R7: state seen right after reset and the two extremes
    @(negedge clk);
    check("R7 reset-state value", int'(val_a), ref_f(0, NA));
    probe_a(0, "R7 low end");
    probe_a((1 << NA) - 1, "R7 high end");
    probe_b((1 << NB) - 1, "R7 high end w");
    // directed corner cases around one block
    probe_a(8, "R4 start");
    probe_a(12, "R3 centre");
    probe_a(10, "R2 lower");
    probe_a(13, "R5 upper");
    probe_a(15, "R5 block end");
    probe_b(16 + 8, "R3 centre w");
    probe_b(16, "R4 start w");
    // exhaustive sweeps
    for (int x = 0; x < (1 << NA); x++) probe_a(x, "sweep");
    for (int x = 0; x < (1 << NB); x++) probe_b(x, "sweep w");
    // scattered revisits
    for (int i = 0; i < 400; i++) begin
      int r;
      r = int'($urandom);
      probe_a(r & ((1 << NA) - 1), "random");
      probe_b((r >> 8) & ((1 << NB) - 1), "random w");
    end
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule